// File: doc/BRIEF.md
# Load-When-Changed Line Hand-off Controller

This block sits beside the cache that currently owns one shared line. Other processors send it "load when changed" requests. Each request names the requester, a word address and the value that requester last saw. When the watched word already holds a different value, the line is handed to the requester straight away. When the value is unchanged, the request is parked in a small ordered wait list instead of being answered. A spinning reader thereby becomes a sleeping one, and the owner wakes it with the line as soon as something actually changes.

A local write to the watched word releases the parked requesters. A wait list that has just become full releases them too. Releasing takes one line beat to the oldest waiter, followed by one record beat for each later waiter. Those record beats go to the new owner, so that it can continue the chain in arrival order. From that point the block no longer owns the line. It refuses further requests until it is reset or told that ownership has come back.

Top module: `lwc_handoff`

## Requirements
- R1: After reset `is_owner` is 1, `xfer_valid` is 0, and the watched word reads as 0.
- R2: A request to the watched address with an empty wait list and an expected value different from the current word is accepted (`req_taken`=1 in that cycle). From the next cycle on, `is_owner` is 0 and a line beat (`xfer_line`=1) is offered with `xfer_dest` and `xfer_wid` equal to the requester.
- R3: A request whose expected value equals the current word, with an empty wait list, is accepted and held: no beat is offered until a release happens.
- R4: A local write to the watched address while at least one request waits starts the release from the next cycle. This holds even when the written value is the same as the old one.
- R5: A request that finds others waiting is placed behind them, whatever its expected value. A release offers the line beat to the oldest waiter. It then offers one record beat (`xfer_line`=0) per later waiter, in arrival order, each with `xfer_dest` equal to the oldest waiter and carrying that waiter's ID in `xfer_wid` and expected value in `xfer_wexp`.
- R6: The push that fills the last of the DEPTH (4) wait slots starts a release from the next cycle, with no write needed.
- R7: When a write to the watched word and a request arrive in the same cycle, the write is applied first. The request is then compared against the newly written value. If a request was already waiting, the write releases the list and the new request joins its tail.
- R8: An offered beat stays valid with unchanged fields until `xfer_ready` is 1. A beat is consumed only in a cycle where `xfer_valid` and `xfer_ready` are both 1.
- R9: Writes and requests to any address other than the watched one change nothing: no release, no entry, and neither `req_taken` nor `req_refused`.
- R10: While `is_owner` is 0, a request to the watched address gets `req_refused`=1 and `req_taken`=0. A pulse on `own_restore`, once no beats remain to be sent, sets `is_owner` back to 1 from the next cycle.
- R11: Each release carries exactly one line beat, and it is the first beat of that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Local write strobe |
| wr_addr | input | 16 | Local write word address |
| wr_data | input | 32 | Local write data |
| req_valid | input | 1 | Remote load-when-changed request present |
| req_id | input | 3 | Requesting processor ID |
| req_addr | input | 16 | Requested word address |
| req_expect | input | 32 | Value the requester expects to see |
| own_restore | input | 1 | Ownership of the line has come back |
| xfer_ready | input | 1 | Transfer sink accepts the offered beat |
| req_taken | output | 1 | Request accepted this cycle |
| req_refused | output | 1 | Request refused this cycle (not owner) |
| is_owner | output | 1 | Block currently owns the line |
| xfer_valid | output | 1 | A transfer beat is offered |
| xfer_dest | output | 3 | Processor receiving the beat (the new owner) |
| xfer_line | output | 1 | 1 = line beat, 0 = waiter record beat |
| xfer_wid | output | 3 | Waiter ID carried by the beat |
| xfer_wexp | output | 32 | Waiter expected value carried by the beat |

## Verification
The hardest situation to reach from the ports is a write and a request landing in the same cycle while the wait list is non-empty. In that case the release and the tail append must happen on one edge. The stimulus first parks a waiter whose expected value matches a freshly written word. It then drives a write and a second request together, and expects both waiters to appear in order behind a single line beat. Back-pressure on the transfer port and the fill-triggered release are reached by holding `xfer_ready` low, and by sending four matching requests on consecutive cycles.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  localparam int LWC_ID_W   = 3;
  localparam int LWC_DATA_W = 32;

  typedef struct packed {
    logic [LWC_ID_W-1:0]   id;
    logic [LWC_DATA_W-1:0] expv;
  } lwc_waiter_t;

  // A requester may take the line at once only if its snapshot is stale.
  function automatic logic value_moved(input logic [LWC_DATA_W-1:0] now_v,
                                       input logic [LWC_DATA_W-1:0] seen_v);
    return now_v != seen_v;
  endfunction

  // Word value a same-cycle request is compared against: the write wins.
  function automatic logic [LWC_DATA_W-1:0] word_after_write(
      input logic                  hit,
      input logic [LWC_DATA_W-1:0] wdata,
      input logic [LWC_DATA_W-1:0] held);
    return hit ? wdata : held;
  endfunction
endpackage

// File: rtl/lwc_wait_fifo.sv
module lwc_wait_fifo
  import lwc_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  lwc_waiter_t   push_ent,
  input  logic          pop,
  output lwc_waiter_t   head,
  output logic [CW-1:0] fill
);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

  lwc_waiter_t   slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_ent;
        wr_ptr        <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head = slots[rd_ptr];

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill < CW'(DEPTH)));
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fill != '0));
endmodule

// File: rtl/lwc_release_ctrl.sv
module lwc_release_ctrl
  import lwc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WATCH_ADDR = '0,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  owner,
  input  logic [CW-1:0]         fill,
  input  logic [LWC_ID_W-1:0]   head_id,
  input  logic [LWC_DATA_W-1:0] word_q,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [LWC_DATA_W-1:0] wr_data,
  input  logic                  req_valid,
  input  logic [LWC_ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LWC_DATA_W-1:0] req_expect,
  output logic                  wr_hit,
  output logic                  push,
  output logic                  release_now,
  output logic [LWC_ID_W-1:0]   next_owner,
  output logic                  taken,
  output logic                  refused
);
  localparam logic [CW-1:0] ONE_SHORT = CW'(DEPTH - 1);

  logic                  req_hit;
  logic                  list_empty;
  logic [LWC_DATA_W-1:0] cmp_word;
  logic                  stale_now;
  logic                  write_wakes;
  logic                  fill_wakes;

  assign wr_hit     = wr_en && (wr_addr == WATCH_ADDR);
  assign req_hit    = req_valid && (req_addr == WATCH_ADDR);
  assign list_empty = (fill == '0);
  assign cmp_word   = word_after_write(wr_hit, wr_data, word_q);

  assign taken   = req_hit && owner;
  assign refused = req_hit && !owner;
  assign push    = taken;

  assign stale_now   = push && list_empty && value_moved(cmp_word, req_expect);
  assign write_wakes = owner && wr_hit && !list_empty;
  assign fill_wakes  = push && (fill == ONE_SHORT);

  assign release_now = stale_now || write_wakes || fill_wakes;
  assign next_owner  = list_empty ? req_id : head_id;

  a_r10_taken_xor_refused: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken && refused));
  a_r9_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr != WATCH_ADDR) |-> !(taken || refused));
endmodule

// File: rtl/lwc_owner_fsm.sv
module lwc_owner_fsm
  import lwc_pkg::*;
#(
  parameter bit RESET_OWNER = 1'b1,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                release_now,
  input  logic [LWC_ID_W-1:0] next_owner,
  input  logic [CW-1:0]       fill,
  input  logic                own_restore,
  input  logic                xfer_ready,
  output logic                owner,
  output logic                draining,
  output logic                first_beat,
  output logic [LWC_ID_W-1:0] dest,
  output logic                pop
);
  logic last_beat;

  assign pop       = draining && xfer_ready;
  assign last_beat = (fill == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner      <= RESET_OWNER;
      draining   <= 1'b0;
      first_beat <= 1'b0;
      dest       <= '0;
    end else if (release_now) begin
      owner      <= 1'b0;
      draining   <= 1'b1;
      first_beat <= 1'b1;
      dest       <= next_owner;
    end else if (pop) begin
      first_beat <= 1'b0;
      if (last_beat) draining <= 1'b0;
    end else if (!owner && !draining && own_restore) begin
      owner <= 1'b1;
    end
  end

  a_r2_release_drops_owner: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> (draining && !owner && first_beat));
  a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (draining && !xfer_ready) |=> (draining && $stable(dest) && $stable(first_beat)));
  a_r11_single_line_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && first_beat) |=> !first_beat);
  a_r10_no_owner_while_drain: assert property (@(posedge clk) disable iff (!rst_n)
    draining |-> !owner);
endmodule

// File: rtl/lwc_handoff.sv
module lwc_handoff
  import lwc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WATCH_ADDR = 16'h0040,
  parameter int DEPTH = 4,
  parameter bit RESET_OWNER = 1'b1,
  parameter logic [LWC_DATA_W-1:0] RESET_WORD = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [LWC_DATA_W-1:0] wr_data,
  input  logic                  req_valid,
  input  logic [LWC_ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LWC_DATA_W-1:0] req_expect,
  input  logic                  own_restore,
  input  logic                  xfer_ready,
  output logic                  req_taken,
  output logic                  req_refused,
  output logic                  is_owner,
  output logic                  xfer_valid,
  output logic [LWC_ID_W-1:0]   xfer_dest,
  output logic                  xfer_line,
  output logic [LWC_ID_W-1:0]   xfer_wid,
  output logic [LWC_DATA_W-1:0] xfer_wexp
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [LWC_DATA_W-1:0] word_q;
  logic                  wr_hit, push, pop, release_now, draining, first_beat;
  logic [LWC_ID_W-1:0]   next_owner, dest;
  logic [CW-1:0]         fill;
  lwc_waiter_t           head, newcomer;

  assign newcomer = '{id: req_id, expv: req_expect};

  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= RESET_WORD;
    else if (wr_hit) word_q <= wr_data;
  end

  lwc_release_ctrl #(.ADDR_W(ADDR_W), .WATCH_ADDR(WATCH_ADDR), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .owner(is_owner), .fill(fill), .head_id(head.id),
    .word_q(word_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .req_expect(req_expect), .wr_hit(wr_hit), .push(push),
    .release_now(release_now), .next_owner(next_owner),
    .taken(req_taken), .refused(req_refused)
  );

  lwc_wait_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_ent(newcomer), .pop(pop),
    .head(head), .fill(fill)
  );

  lwc_owner_fsm #(.RESET_OWNER(RESET_OWNER), .DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .release_now(release_now), .next_owner(next_owner),
    .fill(fill), .own_restore(own_restore), .xfer_ready(xfer_ready),
    .owner(is_owner), .draining(draining), .first_beat(first_beat),
    .dest(dest), .pop(pop)
  );

  assign xfer_valid = draining;
  assign xfer_dest  = dest;
  assign xfer_line  = draining && first_beat;
  assign xfer_wid   = head.id;
  assign xfer_wexp  = head.expv;

  a_r6_full_means_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH)) |-> xfer_valid);
  a_r3_idle_owner_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_owner |-> !xfer_valid);
  a_r4_write_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (is_owner && wr_hit && fill != '0) |=> xfer_valid);
endmodule

// File: tb/lwc_handoff_bench.sv
`timescale 1ns/1ps
module lwc_handoff_bench;
  localparam logic [15:0] WA = 16'h0040;
  localparam logic [15:0] OA = 16'h0044;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, req_valid = 0, own_restore = 0, xfer_ready = 1;
  logic [15:0] wr_addr = '0, req_addr = '0;
  logic [31:0] wr_data = '0, req_expect = '0;
  logic [2:0]  req_id = '0;
  logic        req_taken, req_refused, is_owner, xfer_valid, xfer_line;
  logic [2:0]  xfer_dest, xfer_wid;
  logic [31:0] xfer_wexp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]  dest;
    logic        line;
    logic [2:0]  wid;
    logic [31:0] wexp;
  } beat_t;
  beat_t sb[$];

  always #2.5 clk = ~clk;

  lwc_handoff u_lwc_handoff (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .req_expect(req_expect), .own_restore(own_restore), .xfer_ready(xfer_ready),
    .req_taken(req_taken), .req_refused(req_refused), .is_owner(is_owner),
    .xfer_valid(xfer_valid), .xfer_dest(xfer_dest), .xfer_line(xfer_line),
    .xfer_wid(xfer_wid), .xfer_wexp(xfer_wexp)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_beat(input logic [2:0] d, input logic l, input logic [2:0] w,
                             input logic [31:0] e);
    beat_t b;
    b.dest = d; b.line = l; b.wid = w; b.wexp = e;
    sb.push_back(b);
  endtask

  // Drives one cycle of stimulus starting at a falling edge.
  task automatic drive(input bit we, input logic [15:0] wa, input logic [31:0] wd,
                       input bit rv, input logic [2:0] rid, input logic [15:0] ra,
                       input logic [31:0] re);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    req_valid = rv; req_id = rid; req_addr = ra; req_expect = re;
    own_restore = 0;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 0, '0, '0, '0);
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 40 && (sb.size() != 0 || xfer_valid); i++) idle(1);
    check(sb.size() == 0 && !xfer_valid, req, sb.size(), 0);
  endtask

  task automatic restore();
    @(negedge clk);
    wr_en = 0; req_valid = 0; own_restore = 1;
    @(negedge clk);
    own_restore = 0;
    #1;
    check(is_owner == 1, "R10 restore", is_owner, 1);
  endtask

  // Monitor: compares each consumed beat against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && xfer_valid && xfer_ready) begin
        if (sb.size() == 0) begin
          check(0, "R5 unexpected beat", xfer_wid, -1);
        end else begin
          beat_t b;
          b = sb.pop_front();
          check(xfer_dest == b.dest, "R5 beat dest", xfer_dest, b.dest);
          check(xfer_line == b.line, "R11 beat kind", xfer_line, b.line);
          check(xfer_wid == b.wid, "R5 beat waiter id", xfer_wid, b.wid);
          check(xfer_wexp == b.wexp, "R5 beat waiter value", xfer_wexp, b.wexp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check(is_owner == 1, "R1 owner after reset", is_owner, 1);
    check(xfer_valid == 0, "R1 no beat after reset", xfer_valid, 0);

    // R1 word reset to 0: a request expecting 0 must be held, not served.
    drive(0, '0, '0, 1, 3'd7, WA, 32'd0);
    check(req_taken == 1, "R1 taken", req_taken, 1);
    idle(2);
    check(xfer_valid == 0, "R1 word is zero", xfer_valid, 0);
    // release it with a write, then restore ownership
    expect_beat(3'd7, 1, 3'd7, 32'd0);
    drive(1, WA, 32'd5, 0, '0, '0, '0);
    wait_drain("R4 release single waiter");
    restore();

    // R3: equal value is held
    drive(0, '0, '0, 1, 3'd1, WA, 32'd5);
    check(req_taken == 1 && req_refused == 0, "R3 accepted", req_taken, 1);
    idle(3);
    check(xfer_valid == 0, "R3 held, no beat", xfer_valid, 0);

    // R9: foreign write and foreign request do nothing
    drive(1, OA, 32'd99, 0, '0, '0, '0);
    idle(2);
    check(xfer_valid == 0, "R9 foreign write no release", xfer_valid, 0);
    drive(0, '0, '0, 1, 3'd6, OA, 32'd1);
    check(req_taken == 0 && req_refused == 0, "R9 foreign request ignored",
          {req_taken, req_refused}, 0);

    // R5: later differing request queues behind, then R4 write releases in order
    drive(0, '0, '0, 1, 3'd2, WA, 32'd7);
    check(req_taken == 1, "R5 second waiter taken", req_taken, 1);
    idle(2);
    check(xfer_valid == 0, "R5 differing waiter still queued", xfer_valid, 0);
    expect_beat(3'd1, 1, 3'd1, 32'd5);
    expect_beat(3'd1, 0, 3'd2, 32'd7);
    drive(1, WA, 32'd6, 0, '0, '0, '0);
    idle(1);
    check(is_owner == 0, "R4 owner dropped after write", is_owner, 1'b0);
    wait_drain("R4 write release drained");

    // R10: refused while not owner
    drive(0, '0, '0, 1, 3'd3, WA, 32'd0);
    check(req_refused == 1 && req_taken == 0, "R10 refused", req_refused, 1);
    idle(1);
    check(xfer_valid == 0, "R10 refused adds nothing", xfer_valid, 0);
    restore();

    // R2: stale expectation served at once
    expect_beat(3'd3, 1, 3'd3, 32'd0);
    drive(0, '0, '0, 1, 3'd3, WA, 32'd0);
    check(req_taken == 1, "R2 taken", req_taken, 1);
    idle(1);
    check(is_owner == 0 && xfer_valid == 1, "R2 immediate line beat",
          {is_owner, xfer_valid}, 1);
    wait_drain("R2 drained");
    restore();

    // R8: back-pressure holds the beat
    xfer_ready = 0;
    expect_beat(3'd4, 1, 3'd4, 32'd1);
    drive(0, '0, '0, 1, 3'd4, WA, 32'd1);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      check(xfer_valid == 1 && xfer_dest == 3'd4 && xfer_line == 1,
            "R8 beat held", xfer_dest, 4);
    end
    check(sb.size() == 1, "R8 not consumed without ready", sb.size(), 1);
    xfer_ready = 1;
    wait_drain("R8 drained after ready");
    restore();

    // R6: fourth matching request fills the list and releases it
    for (int k = 0; k < 3; k++) begin
      drive(0, '0, '0, 1, 3'(k), WA, 32'd6);
      check(req_taken == 1, "R6 taken", req_taken, 1);
    end
    idle(1);
    check(xfer_valid == 0, "R6 no release before full", xfer_valid, 0);
    expect_beat(3'd0, 1, 3'd0, 32'd6);
    expect_beat(3'd0, 0, 3'd1, 32'd6);
    expect_beat(3'd0, 0, 3'd2, 32'd6);
    expect_beat(3'd0, 0, 3'd3, 32'd6);
    drive(0, '0, '0, 1, 3'd3, WA, 32'd6);
    idle(1);
    check(xfer_valid == 1 && is_owner == 0, "R6 release at full", xfer_valid, 1);
    wait_drain("R6 drained");
    restore();

    // R7: same-cycle write then compare against new value (equal -> held)
    drive(1, WA, 32'd9, 1, 3'd5, WA, 32'd9);
    check(req_taken == 1, "R7 taken", req_taken, 1);
    idle(2);
    check(xfer_valid == 0, "R7 compared with new value, held", xfer_valid, 0);
    // R7: write with waiter plus new request: release and append at tail
    expect_beat(3'd5, 1, 3'd5, 32'd9);
    expect_beat(3'd5, 0, 3'd6, 32'd6);
    drive(1, WA, 32'd9, 1, 3'd6, WA, 32'd6);
    check(req_taken == 1, "R7 appended request taken", req_taken, 1);
    wait_drain("R7 release with tail append");
    restore();

    // R7: same-cycle write makes the expectation stale -> immediate
    expect_beat(3'd2, 1, 3'd2, 32'd9);
    drive(1, WA, 32'd10, 1, 3'd2, WA, 32'd9);
    idle(1);
    check(xfer_valid == 1, "R7 stale against new value", xfer_valid, 1);
    wait_drain("R7 immediate drained");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule